// File: doc/BRIEF.md
# Gray-Coded Clock-Crossing Counter

This block keeps a small counter in one clock domain and makes its value readable in a second, unrelated clock domain. The counter advances when its enable is high and is stored in reflected Gray form, so each step flips a single bit of the stored word. That word leaves a source-domain register directly, with no logic between it and the crossing.

On the destination side the word passes through a cascade of flip-flops clocked by the destination clock. The last stage is decoded back to binary and registered as the count output. A flop that samples the one moving bit mid-transition can only settle to the old code or the new code. The destination therefore sees either the previous count or the next one, never an unrelated value. In the worst case a step arrives one destination cycle late.

The synchronizer depth is a parameter. Two stages is the default, and a third stage may be chosen where a lower failure rate is worth one more cycle of latency. Each domain has its own active-low asynchronous reset.

Top module: `gray_xdomain_counter`

## Requirements
- R1: While either reset is low, that domain's state is zero. After both resets are released with `src_en` low, `dst_count` reads 0.
- R2: Each source clock edge with `src_en` high advances the count by one modulo 16. The stored word is the reflected Gray code of the count (gray = bin XOR (bin >> 1)), and the count wraps from 15 to 0.
- R3: The word crossing the boundary changes in at most one bit per source clock. This includes the wrap from Gray 1000 to 0000.
- R4: A source clock edge with `src_en` low leaves the count and the crossing word unchanged.
- R5: `dst_count` is the binary decode of the last synchronizer stage (bin[i] = XOR of gray bits i and above). It only ever equals a count value the source held within the last few source cycles.
- R6: A single source step appears on `dst_count` SYNC_STAGES+1 destination edges after the source edge that made it, or one edge later.
- R7: With the default depth of 2, or a depth of 3, `dst_count` shows the same sequence of values. Only the latency differs.
- R8: When the destination clock is faster than the source clock, `dst_count` moves by 0 or +1 (mod 16) per destination cycle and never backward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain asynchronous reset, active low |
| src_en | input | 1 | Count enable, sampled on `src_clk` |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain asynchronous reset, active low |
| dst_count | output | CNT_W (4) | Binary count as seen in the destination domain |

## Verification
A count step takes effect in the source register on the `src_clk` edge that samples `src_en`. It reaches `dst_count` SYNC_STAGES+1 `dst_clk` edges later, or one edge later still when the change lands close to a destination edge. The latency test therefore counts destination rising edges after the stepping source edge and samples 1 ns after each one. It accepts exactly those two edge counts for each of the two depths instrumented. Running checks sample at destination falling edges. Each decoded value is compared against a six-entry history of the bench's own count model, and against the previous sample for forward-only, single-step motion. Settled values are compared only after the enable has been low for ten source cycles, which is longer than any path through the chain.

// File: rtl/gxc_pkg.sv
`timescale 1ns/100ps
package gxc_pkg;
    localparam int GXC_CNT_W       = 4;
    localparam int GXC_MIN_STAGES  = 2;
    localparam int GXC_DEF_STAGES  = 2;
endpackage

// File: rtl/gxc_src_counter.sv
`timescale 1ns/100ps
module gxc_src_counter #(
    parameter int WIDTH = gxc_pkg::GXC_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [WIDTH-1:0] gray_q
);
    logic [WIDTH-1:0] bin_q;
    logic [WIDTH-1:0] bin_d;
    logic [WIDTH-1:0] gray_d;

    always_comb begin
        bin_d  = en ? bin_q + WIDTH'(1) : bin_q;
        gray_d = bin_d ^ (bin_d >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_d;
            gray_q <= gray_d;
        end
    end
endmodule

// File: rtl/gxc_sync_chain.sv
`timescale 1ns/100ps
module gxc_sync_chain #(
    parameter int WIDTH  = gxc_pkg::GXC_CNT_W,
    parameter int STAGES = gxc_pkg::GXC_DEF_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gxc_gray_decode.sv
`timescale 1ns/100ps
module gxc_gray_decode #(
    parameter int WIDTH = gxc_pkg::GXC_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] gray_in,
    output logic [WIDTH-1:0] bin_q
);
    logic [WIDTH-1:0] bin_d;

    always_comb begin
        bin_d[WIDTH-1] = gray_in[WIDTH-1];
        for (int i = WIDTH - 2; i >= 0; i--) begin
            bin_d[i] = bin_d[i+1] ^ gray_in[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bin_q <= '0;
        else        bin_q <= bin_d;
    end
endmodule

// File: rtl/gray_xdomain_counter.sv
`timescale 1ns/100ps
module gray_xdomain_counter #(
    parameter int CNT_W       = gxc_pkg::GXC_CNT_W,
    parameter int SYNC_STAGES = gxc_pkg::GXC_DEF_STAGES
) (
    input  logic             src_clk,
    input  logic             src_rst_n,
    input  logic             src_en,
    input  logic             dst_clk,
    input  logic             dst_rst_n,
    output logic [CNT_W-1:0] dst_count
);
    localparam int STAGES_USED = (SYNC_STAGES < gxc_pkg::GXC_MIN_STAGES)
                                 ? gxc_pkg::GXC_MIN_STAGES : SYNC_STAGES;

    logic [CNT_W-1:0] src_gray_q;
    logic [CNT_W-1:0] sync_gray;

    gxc_src_counter #(.WIDTH(CNT_W)) u_src (
        .clk    (src_clk),
        .rst_n  (src_rst_n),
        .en     (src_en),
        .gray_q (src_gray_q)
    );

    gxc_sync_chain #(.WIDTH(CNT_W), .STAGES(STAGES_USED)) u_sync (
        .clk      (dst_clk),
        .rst_n    (dst_rst_n),
        .async_in (src_gray_q),
        .sync_out (sync_gray)
    );

    gxc_gray_decode #(.WIDTH(CNT_W)) u_dec (
        .clk     (dst_clk),
        .rst_n   (dst_rst_n),
        .gray_in (sync_gray),
        .bin_q   (dst_count)
    );
endmodule

// File: rtl/gxc_checker.sv
`timescale 1ns/100ps
module gxc_checker #(
    parameter int WIDTH = 4
) (
    input logic             src_clk,
    input logic             src_rst_n,
    input logic             src_en,
    input logic [WIDTH-1:0] src_gray,
    input logic             dst_clk,
    input logic             dst_rst_n,
    input logic [WIDTH-1:0] dst_sync,
    input logic [WIDTH-1:0] dst_count
);
    localparam logic [WIDTH-1:0] LAST_GRAY = {1'b1, {(WIDTH-1){1'b0}}};

    function automatic logic [WIDTH-1:0] g2b(input logic [WIDTH-1:0] g);
        logic [WIDTH-1:0] b;
        b[WIDTH-1] = g[WIDTH-1];
        for (int i = WIDTH - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    assert_src_one_bit_R3: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        $countones(src_gray ^ $past(src_gray)) <= 1);

    assert_src_hold_R4: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        !$past(src_en) |-> $stable(src_gray));

    assert_src_advance_R2: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        $past(src_en) |-> (src_gray != $past(src_gray)));

    assert_src_wrap_R2: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        ($past(src_en) && $past(src_gray) == LAST_GRAY) |-> (src_gray == '0));

    assert_dst_decode_R5: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        dst_count == g2b($past(dst_sync)));
endmodule

bind gray_xdomain_counter gxc_checker #(.WIDTH(CNT_W)) u_chk (
    .src_clk   (src_clk),
    .src_rst_n (src_rst_n),
    .src_en    (src_en),
    .src_gray  (src_gray_q),
    .dst_clk   (dst_clk),
    .dst_rst_n (dst_rst_n),
    .dst_sync  (sync_gray),
    .dst_count (dst_count)
);

// File: tb/gray_xdomain_counter_tb.sv
`timescale 1ns/100ps
module gray_xdomain_counter_tb;
    localparam int W = 4;

    logic src_clk = 1'b0;
    logic dst_clk = 1'b0;
    logic src_rst_n = 1'b0;
    logic dst_rst_n = 1'b0;
    logic src_en = 1'b0;
    logic [W-1:0] cnt2;
    logic [W-1:0] cnt3;

    int checks = 0;
    int failures = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    always #10 src_clk = ~src_clk;
    initial begin
        #3;
        forever #6.5 dst_clk = ~dst_clk;
    end

    gray_xdomain_counter #(.CNT_W(W), .SYNC_STAGES(2)) u_dut (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .src_en(src_en),
        .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_count(cnt2));

    gray_xdomain_counter #(.CNT_W(W), .SYNC_STAGES(3)) u_dut3 (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .src_en(src_en),
        .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_count(cnt3));

    function automatic logic [W-1:0] to_gray(input logic [W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // independent model of the source count and its recent history
    logic [W-1:0] model;
    logic [W-1:0] hist [6];
    always @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) begin
            model = '0;
            for (int i = 0; i < 6; i++) hist[i] = '0;
        end else begin
            if (src_en) model = model + W'(1);
            for (int i = 5; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = model;
        end
    end

    function automatic bit in_hist(input logic [W-1:0] v);
        for (int i = 0; i < 6; i++) if (hist[i] == v) return 1'b1;
        return 1'b0;
    endfunction

    logic [W-1:0] prev2 = '0;
    logic [W-1:0] prev3 = '0;
    always @(negedge dst_clk) begin
        if (mon_on) begin
            check(in_hist(cnt2), "R5 depth2 value in recent history", int'(cnt2), int'(hist[0]));
            check(in_hist(cnt3), "R5 depth3 value in recent history", int'(cnt3), int'(hist[0]));
            check(W'(cnt2 - prev2) <= W'(1), "R8 depth2 forward step", int'(cnt2), int'(prev2));
            check(W'(cnt3 - prev3) <= W'(1), "R8 depth3 forward step", int'(cnt3), int'(prev3));
            check($countones(to_gray(cnt2) ^ to_gray(prev2)) <= 1, "R3 single bit change",
                  int'(cnt2), int'(prev2));
            prev2 = cnt2;
            prev3 = cnt3;
        end
    end

    task automatic src_cycles(input int n);
        repeat (n) @(negedge src_clk);
    endtask

    initial begin
        int lat2;
        int lat3;
        logic [W-1:0] target;
        void'($urandom(32'h1234_5eed));

        // R1: reset state
        src_cycles(3);
        check(cnt2 == '0, "R1 depth2 in reset", int'(cnt2), 0);
        check(cnt3 == '0, "R1 depth3 in reset", int'(cnt3), 0);
        src_rst_n = 1'b1;
        @(negedge dst_clk);
        dst_rst_n = 1'b1;
        src_cycles(6);
        check(cnt2 == '0, "R1 depth2 after release", int'(cnt2), 0);
        check(cnt3 == '0, "R1 depth3 after release", int'(cnt3), 0);
        mon_on = 1'b1;

        // R2: twenty steps, wrapping once
        src_en = 1'b1;
        src_cycles(20);
        src_en = 1'b0;
        src_cycles(10);
        check(cnt2 == W'(20 % 16), "R2 depth2 wrap count", int'(cnt2), 20 % 16);
        check(cnt3 == W'(20 % 16), "R2 depth3 wrap count", int'(cnt3), 20 % 16);
        check(cnt2 == cnt3, "R7 depths agree", int'(cnt3), int'(cnt2));

        // R4: hold while disabled
        src_cycles(15);
        check(cnt2 == W'(4), "R4 depth2 hold", int'(cnt2), 4);
        check(cnt3 == W'(4), "R4 depth3 hold", int'(cnt3), 4);

        // R6: latency of one step in destination edges
        target = W'(5);
        src_en = 1'b1;
        @(posedge src_clk);
        fork
            begin @(negedge src_clk); src_en = 1'b0; end
        join_none
        lat2 = 0;
        lat3 = 0;
        for (int n = 1; n <= 8; n++) begin
            @(posedge dst_clk);
            #1;
            if (lat2 == 0 && cnt2 == target) lat2 = n;
            if (lat3 == 0 && cnt3 == target) lat3 = n;
        end
        check(lat2 == 3 || lat2 == 4, "R6 depth2 latency edges", lat2, 3);
        check(lat3 == 4 || lat3 == 5, "R6 depth3 latency edges", lat3, 4);

        // random enable pattern, monitors check R3 R5 R8 continuously
        src_cycles(2);
        repeat (3000) begin
            src_en = ($urandom_range(0, 9) < 7);
            @(negedge src_clk);
        end
        src_en = 1'b0;
        src_cycles(10);
        check(cnt2 == model, "R2 depth2 final count", int'(cnt2), int'(model));
        check(cnt3 == model, "R7 depth3 final count", int'(cnt3), int'(model));

        // burst of exactly sixteen steps returns to same value
        target = model;
        src_en = 1'b1;
        src_cycles(16);
        src_en = 1'b0;
        src_cycles(10);
        check(cnt2 == target, "R2 full cycle depth2", int'(cnt2), int'(target));
        check(cnt3 == target, "R2 full cycle depth3", int'(cnt3), int'(target));

        mon_on = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule